// File: doc/BRIEF.md
# Bit-Serial Adder with Registered Sum

The block adds two unsigned binary numbers one bit position per clock. The lowest-order bits come first. On each clock where `inValid` is high it takes one bit from each operand. A four-state register holds the running carry and the sum bit just produced. The sum output is decoded from that register alone, so each sum bit appears on the cycle after the pair that caused it.

A caller raises `opStart` together with the first pair of a new addition. That pair is then added with an incoming carry of zero, whatever carry the state still holds. After the last pair, the final carry can be read from `carryOut`. A synchronous reset returns the machine to its start state.

Top module: `serial_adder_top`

## Requirements
- R1: The state is two bits, {carry, sum}, in that order: start = 00, sum-only = 01, carry-only = 10, both = 11. While `rst` is high at a clock edge, the state goes to 00, so `sumOut` = 0 and `carryOut` = 0 after that edge.
- R2: On an edge with `inValid` = 1, the new sum bit is a ^ b ^ c. Here c is the stored carry, or 0 if `opStart` = 1.
- R3: On an edge with `inValid` = 1, the new carry is the majority of a, b and c, with c defined as in R2.
- R4: `sumOut` depends only on the state: it is 1 in the two states whose sum bit is 1. It changes only on the edge after a valid pair, never combinationally with the inputs.
- R5: On an edge with `inValid` = 0, the state holds. `sumOut` and `carryOut` stay the same, whatever `a`, `b` and `opStart` are.
- R6: `opStart` with a valid pair forces the incoming carry to 0, even when the stored carry is 1.
- R7: For a stream of N pairs sent low-order first, starting with `opStart`, the N sum bits, each read one cycle after its pair, give the low N bits of A+B. `carryOut` after the last pair is bit N of A+B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to the start state, active high |
| inValid | input | 1 | The operand bit pair on `a` and `b` is valid this cycle |
| opStart | input | 1 | The pair this cycle is the lowest-order pair of a new addition |
| a | input | 1 | Operand A bit |
| b | input | 1 | Operand B bit |
| sumOut | output | 1 | Registered sum bit, decoded from the state |
| carryOut | output | 1 | Present carry held in the state |

## Verification
The bench takes the stored carry into every input pair. A design that treated the 00-with-carry input like the start state would lose the carry and return a sum bit of 0 where 1 is expected. The bench inserts idle cycles in the middle of an addition while toggling the operand inputs. A design that acted on an invalid pair would corrupt the held carry or sum. It raises `opStart` while the carry is 1; a design that ignored it would add an extra one to the low bit. It also checks that the sum lags its pair by exactly one cycle. A combinational sum would show the new value too early.

// File: rtl/serial_adder_pkg.sv
package serial_adder_pkg;
  typedef struct packed {
    logic carry;
    logic sum;
  } addState_t;

  localparam addState_t ST_START = '{carry: 1'b0, sum: 1'b0};

  typedef struct packed {
    logic loadEn;
    logic clearCarry;
  } addCtrl_t;
endpackage

// File: rtl/serial_adder_ctrl.sv
module serial_adder_ctrl
  import serial_adder_pkg::*;
(
  input  logic     inValid,
  input  logic     opStart,
  output addCtrl_t ctrl
);
  always_comb begin
    ctrl.loadEn     = inValid;
    ctrl.clearCarry = inValid & opStart;
  end
endmodule

// File: rtl/serial_adder_dp.sv
module serial_adder_dp
  import serial_adder_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  addCtrl_t ctrl,
  input  logic     a,
  input  logic     b,
  output addState_t state
);
  addState_t nextState;
  logic carryIn;

  always_comb begin
    carryIn         = ctrl.clearCarry ? 1'b0 : state.carry;
    nextState.sum   = a ^ b ^ carryIn;
    nextState.carry = (a & b) | (a & carryIn) | (b & carryIn);
  end

  always_ff @(posedge clk) begin
    if (rst)              state <= ST_START;
    else if (ctrl.loadEn) state <= nextState;
  end

  // R5: an idle cycle leaves the state unchanged
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loadEn |=> $stable(state));
  // R2 (and R6): the new sum bit follows the addition rule
  a_r2_sum: assert property (@(posedge clk) disable iff (rst)
    ctrl.loadEn |=> state.sum == ($past(a) ^ $past(b) ^
      ($past(ctrl.clearCarry) ? 1'b0 : $past(state.carry))));
  // R6: a start with a pair of zeros leaves no carry
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    (ctrl.clearCarry && !a && !b) |=> state == ST_START);
  // R3: when both operand bits are 1, the carry must come out 1
  a_r3_carry: assert property (@(posedge clk) disable iff (rst)
    (ctrl.loadEn && a && b) |=> state.carry);
endmodule

// File: rtl/serial_adder_top.sv
module serial_adder_top
  import serial_adder_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic inValid,
  input  logic opStart,
  input  logic a,
  input  logic b,
  output logic sumOut,
  output logic carryOut
);
  addCtrl_t  ctrl;
  addState_t state;

  serial_adder_ctrl u_ctrl (
    .inValid(inValid), .opStart(opStart), .ctrl(ctrl)
  );
  serial_adder_dp u_dp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .a(a), .b(b), .state(state)
  );

  assign sumOut   = state.sum;
  assign carryOut = state.carry;

  // R1: reset sends the outputs to the start state
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!sumOut && !carryOut));
  // R4: the sum output changes only after a valid pair
  a_r4_moore: assert property (@(posedge clk) disable iff (rst)
    !$stable(sumOut) |-> $past(inValid));
endmodule

// File: tb/serial_adder_top_tb.sv
module serial_adder_top_tb;
  logic clk = 0, rst = 1, inValid = 0, opStart = 0, a = 0, b = 0;
  logic sumOut, carryOut;
  int nChecks = 0, nFails = 0;
  bit done = 0;

  localparam int NV = 8;
  localparam int W  = 8;
  localparam logic [W-1:0] OPA [NV] = '{8'h00, 8'hFF, 8'hFF, 8'h5A, 8'h80, 8'h0F, 8'hAA, 8'h37};
  localparam logic [W-1:0] OPB [NV] = '{8'h00, 8'h01, 8'hFF, 8'hA5, 8'h80, 8'hF1, 8'h55, 8'hC9};

  serial_adder_top u_dut (.*);

  always #5 clk = ~clk;

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic ia, input logic ib);
    inValid = v; opStart = s; a = ia; b = ib;
    @(posedge clk); #1;
  endtask

  task automatic addStream(input logic [W-1:0] x, input logic [W-1:0] y, input bit gaps);
    logic [W:0] ref_ = x + y;
    for (int i = 0; i < W; i++) begin
      drive(1, i == 0, x[i], y[i]);
      check("R7 sum bit", sumOut, ref_[i]);
      if (gaps && i == 3) begin
        logic hs = sumOut, hc = carryOut;
        drive(0, 1, ~x[i], ~y[i]);
        check("R5 idle sum", sumOut, hs);
        check("R5 idle carry", carryOut, hc);
      end
    end
    check("R7 final carry", carryOut, ref_[W]);
  endtask

  initial begin
    #50000;
    nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    check("R1 reset sum", sumOut, 1'b0);
    check("R1 reset carry", carryOut, 1'b0);
    rst = 0;
    for (int v = 0; v < NV; v++) addStream(OPA[v], OPB[v], v[0]);
    // R4: the sum lags its pair by one cycle
    drive(1, 1, 0, 0);
    inValid = 1; opStart = 0; a = 1; b = 0; #2;
    check("R4 no combinational sum", sumOut, 1'b0);
    @(posedge clk); #1;
    check("R4 sum after edge", sumOut, 1'b1);
    // R2/R3: with carry 1, the pair 00 gives sum 1 and carry 0
    drive(1, 1, 1, 1);
    check("R3 carry set", carryOut, 1'b1);
    check("R2 sum 0", sumOut, 1'b0);
    drive(1, 0, 0, 0);
    check("R2 carry absorbed", sumOut, 1'b1);
    check("R3 carry cleared", carryOut, 1'b0);
    // R6: a start pulse drops a stored carry
    drive(1, 1, 1, 1);
    drive(1, 1, 1, 0);
    check("R6 start clears carry sum", sumOut, 1'b1);
    check("R6 start clears carry", carryOut, 1'b0);
    // R1: reset from a non-start state
    drive(1, 1, 1, 1);
    rst = 1; @(posedge clk); #1; rst = 0;
    check("R1 reset carry", carryOut, 1'b0);
    check("R1 reset sum", sumOut, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule